// File: doc/BRIEF.md
# Self-Triggered Channel Hit Acquisition Manager

This block sits on the acquisition side of a sixteen-channel self-triggered front end. Each channel brings in one trigger line from its discriminator. The block keeps a Gray-coded coarse-time counter. For every channel it runs a small two-cell FIFO that stands for the analogue track-and-hold storage. A cell holds one charge sample and one fine-time sample, and one trigger event writes both.

When a channel's latched trigger rises, the block takes the next free cell of that channel. It pulses the hold strobe for that cell, stores the current Gray timestamp next to it and marks the cell valid. A converter downstream reads the oldest entry of any channel through a small read port. When it has finished with that entry it asks for it to be erased. The block then pulses the erase strobe for that cell and frees it.

Triggers keep being accepted while other entries are converted or erased. A channel whose two cells are both full drops further triggers and raises a sticky overflow flag. An OR of all latched triggers is also brought out.

Top module: `hitacq_top`

## Requirements
- R1: After a synchronous reset the coarse time reads zero, every cell is empty, every overflow flag and hit status bit is low, and no hold or erase strobe is active.
- R2: The coarse-time binary count advances by one every PRESCALE clocks (default 4). It is output in Gray code g = b ^ (b >> 1), so successive output values differ in at most one bit.
- R3: trig_or is high in the cycle after any trig_in bit was sampled high, and it is low in the cycle after all trig_in bits were sampled low.
- R4: Only a rising edge of a channel's latched trigger creates an entry. A trigger held high for many cycles produces exactly one entry.
- R5: A trigger first sampled high at clock edge k gives a hold_strobe pulse of exactly one cycle after edge k+1. The pulse is on bit ch*2+cell, and cell_valid shows that bit set after the same edge.
- R6: The cells of a channel are written in the order 0, 1, 0, 1 and so on. wr_col[ch] shows the cell that the next hit of that channel will use.
- R7: The stored timestamp is the coarse_gray value seen in the cycle between edges k and k+1. rd_ts and rd_col show the timestamp and cell index of the oldest entry of channel rd_ch.
- R8: A rising trigger on a channel whose two cells are full at that edge is dropped: no strobe is issued and no cell changes. It sets overflow[ch], which stays set until reset.
- R9: An erase request for channel erase_ch with erase_req high at an edge frees that channel's oldest cell. It pulses erase_strobe for that cell for one cycle after the edge, and the read port moves on to the next entry.
- R10: An erase request for an empty channel is ignored: no erase strobe is issued and no valid or overflow bit changes.
- R11: Channels are independent. Several channels can be written at the same edge. A channel can accept a new hit at the same edge as one of its older entries is erased, and no other channel is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 16 | One discriminator trigger per channel |
| erase_req | input | 1 | Request to free the oldest entry of erase_ch |
| erase_ch | input | 4 | Channel that the erase request names |
| rd_ch | input | 4 | Channel shown on the read port |
| coarse_gray | output | 24 | Coarse-time counter in Gray code |
| trig_or | output | 1 | OR of all latched triggers |
| hit_status | output | 16 | Channel holds at least one valid entry |
| overflow | output | 16 | Sticky flag: a hit was dropped on a full channel |
| cell_valid | output | 32 | Valid flag per cell, bit ch*2+cell |
| hold_strobe | output | 32 | One-cycle hold pulse per cell, bit ch*2+cell |
| erase_strobe | output | 32 | One-cycle erase pulse per cell, bit ch*2+cell |
| wr_col | output | 16 | Next cell to be written, one bit per channel |
| rd_col | output | 1 | Oldest cell index of channel rd_ch |
| rd_ts | output | 24 | Timestamp of the oldest entry of channel rd_ch |

## Verification
A trigger sampled at edge k shows on trig_or after edge k, because only the input latch lies between them. Its hold strobe, valid bit and timestamp appear after edge k+1, because the edge detector adds a second register. The bench therefore reads coarse_gray after edge k and checks the strobe, the valid bits and the read port after edge k+1. It then checks once more a cycle later to confirm that the strobe has dropped. Erase requests are taken directly at the edge where they are sampled, so their strobe and the freed cell are checked after that same edge. All inputs are driven and all outputs sampled on the falling clock edge.

// File: rtl/hitacq_pkg.sv
package hitacq_pkg;

    localparam int HA_MAX_W = 64;

    function automatic logic [HA_MAX_W-1:0] bin2gray(input logic [HA_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    typedef struct packed {
        logic wr;
        logic er;
        logic drop;
    } cell_op_t;

endpackage

// File: rtl/hitacq_timebase.sv
module hitacq_timebase #(
    parameter int TS_W     = 24,
    parameter int PRESCALE = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] coarse_gray
);
    import hitacq_pkg::*;

    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PS_W-1:0] ps_cnt;
    logic [TS_W-1:0] bin_cnt;
    logic            tick;

    assign tick = (ps_cnt == PS_W'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_cnt  <= '0;
            bin_cnt <= '0;
        end else if (tick) begin
            ps_cnt  <= '0;
            bin_cnt <= bin_cnt + 1'b1;
        end else begin
            ps_cnt  <= ps_cnt + 1'b1;
        end
    end

    assign coarse_gray = TS_W'(bin2gray(HA_MAX_W'(bin_cnt)));

    // R2: one bit at most changes per clock
    p_gray_step_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(coarse_gray ^ $past(coarse_gray)) <= 1);

    // R2: binary count holds between prescaler ticks
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(bin_cnt));

endmodule

// File: rtl/hitacq_channel.sv
module hitacq_channel #(
    parameter int TS_W  = 24,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             erase_hit,
    input  logic [TS_W-1:0]  ts_now,
    output logic             trig_lat,
    output logic [DEPTH-1:0] hold_stb,
    output logic [DEPTH-1:0] erase_stb,
    output logic [DEPTH-1:0] valid,
    output logic [PTR_W-1:0] wr_col,
    output logic [PTR_W-1:0] rd_col,
    output logic [TS_W-1:0]  rd_ts,
    output logic             overflow
);
    import hitacq_pkg::*;

    logic             trig_q, trig_d;
    logic             rise, full, empty;
    cell_op_t         op;
    logic [DEPTH-1:0] valid_nxt;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [TS_W-1:0]  ts_mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rise  = trig_q & ~trig_d;
    assign full  = &valid;
    assign empty = ~|valid;

    always_comb begin
        op.wr   = rise & ~full;
        op.drop = rise & full;
        op.er   = erase_hit & ~empty;
        valid_nxt = valid;
        if (op.er) valid_nxt[rd_ptr] = 1'b0;
        if (op.wr) valid_nxt[wr_ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q    <= 1'b0;
            trig_d    <= 1'b0;
            hold_stb  <= '0;
            erase_stb <= '0;
            valid     <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            overflow  <= 1'b0;
        end else begin
            trig_q    <= trig_in;
            trig_d    <= trig_q;
            valid     <= valid_nxt;
            hold_stb  <= '0;
            erase_stb <= '0;
            if (op.wr) begin
                hold_stb[wr_ptr] <= 1'b1;
                wr_ptr           <= ptr_inc(wr_ptr);
            end
            if (op.er) begin
                erase_stb[rd_ptr] <= 1'b1;
                rd_ptr            <= ptr_inc(rd_ptr);
            end
            if (op.drop) overflow <= 1'b1;
        end
    end

    for (genvar c = 0; c < DEPTH; c++) begin : g_ts
        always_ff @(posedge clk) begin
            if (rst)                                ts_mem[c] <= '0;
            else if (op.wr && wr_ptr == PTR_W'(c))  ts_mem[c] <= ts_now;
        end
    end

    assign trig_lat = trig_q;
    assign wr_col   = wr_ptr;
    assign rd_col   = rd_ptr;
    assign rd_ts    = ts_mem[rd_ptr];

    // R5: at most one cell held per pulse
    p_hold_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold_stb));

    // R4: a hold pulse only follows a trigger edge
    p_hold_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (|hold_stb) |-> $past(rise));

    // R8: overflow flag is sticky
    p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8: a full channel accepts no write
    p_full_no_hold_r8: assert property (@(posedge clk) disable iff (rst)
        full && !erase_hit |=> hold_stb == '0);

    // R10: erase of an empty channel gives no strobe
    p_erase_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (erase_hit && empty) |=> erase_stb == '0);

    // R6: equal pointers mean the FIFO is full or empty
    p_ptr_consistent_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr == rd_ptr) |-> (full || empty));

endmodule

// File: rtl/hitacq_top.sv
module hitacq_top #(
    parameter int NCH      = 16,
    parameter int DEPTH    = 2,
    parameter int TS_W     = 24,
    parameter int PRESCALE = 4,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         trig_in,
    input  logic                   erase_req,
    input  logic [CH_W-1:0]        erase_ch,
    input  logic [CH_W-1:0]        rd_ch,
    output logic [TS_W-1:0]        coarse_gray,
    output logic                   trig_or,
    output logic [NCH-1:0]         hit_status,
    output logic [NCH-1:0]         overflow,
    output logic [NCH*DEPTH-1:0]   cell_valid,
    output logic [NCH*DEPTH-1:0]   hold_strobe,
    output logic [NCH*DEPTH-1:0]   erase_strobe,
    output logic [NCH*PTR_W-1:0]   wr_col,
    output logic [PTR_W-1:0]       rd_col,
    output logic [TS_W-1:0]        rd_ts
);
    logic [NCH-1:0]   trig_lat;
    logic [TS_W-1:0]  ts_all  [NCH];
    logic [PTR_W-1:0] col_all [NCH];

    hitacq_timebase #(.TS_W(TS_W), .PRESCALE(PRESCALE)) u_tb (
        .clk         (clk),
        .rst         (rst),
        .coarse_gray (coarse_gray)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [DEPTH-1:0] v;
        hitacq_channel #(.TS_W(TS_W), .DEPTH(DEPTH)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .trig_in   (trig_in[i]),
            .erase_hit (erase_req && (erase_ch == CH_W'(i))),
            .ts_now    (coarse_gray),
            .trig_lat  (trig_lat[i]),
            .hold_stb  (hold_strobe[i*DEPTH +: DEPTH]),
            .erase_stb (erase_strobe[i*DEPTH +: DEPTH]),
            .valid     (v),
            .wr_col    (wr_col[i*PTR_W +: PTR_W]),
            .rd_col    (col_all[i]),
            .rd_ts     (ts_all[i]),
            .overflow  (overflow[i])
        );
        assign cell_valid[i*DEPTH +: DEPTH] = v;
        assign hit_status[i] = |v;
    end

    assign trig_or = |trig_lat;
    assign rd_ts   = ts_all[rd_ch];
    assign rd_col  = col_all[rd_ch];

    // R3: any trigger shows on the OR output one cycle later
    p_or_high_r3: assert property (@(posedge clk) disable iff (rst)
        (|trig_in) |=> trig_or);

    // R3: no trigger, no OR output
    p_or_low_r3: assert property (@(posedge clk) disable iff (rst)
        !(|trig_in) |=> !trig_or);

endmodule

// File: tb/hitacq_top_test.sv
module hitacq_top_test;
    localparam int CLK_P = 10;
    localparam int NCH   = 16;
    localparam int PRE   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    trig_in = '0;
    logic              erase_req = 1'b0;
    logic [3:0]        erase_ch = '0;
    logic [3:0]        rd_ch = '0;
    logic [23:0]       coarse_gray;
    logic              trig_or;
    logic [NCH-1:0]    hit_status, overflow, wr_col;
    logic [2*NCH-1:0]  cell_valid, hold_strobe, erase_strobe;
    logic              rd_col;
    logic [23:0]       rd_ts;

    int checks = 0;
    int failures = 0;

    logic [23:0] g0, g1, g15;

    always #(CLK_P/2) clk = ~clk;

    hitacq_top uut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .erase_req(erase_req),
        .erase_ch(erase_ch), .rd_ch(rd_ch), .coarse_gray(coarse_gray),
        .trig_or(trig_or), .hit_status(hit_status), .overflow(overflow),
        .cell_valid(cell_valid), .hold_strobe(hold_strobe),
        .erase_strobe(erase_strobe), .wr_col(wr_col), .rd_col(rd_col),
        .rd_ts(rd_ts)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] gray_to_bin(input logic [23:0] g);
        logic [23:0] b;
        b[23] = g[23];
        for (int i = 22; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic t_reset;
        chk("R1 coarse", 64'(coarse_gray), 0);
        chk("R1 valid", 64'(cell_valid), 0);
        chk("R1 overflow", 64'(overflow), 0);
        chk("R1 hit", 64'(hit_status), 0);
        chk("R1 strobes", 64'(hold_strobe | erase_strobe), 0);
    endtask

    task automatic t_gray;
        logic [23:0] prev;
        int changes = 0;
        int bad = 0;
        prev = coarse_gray;
        for (int n = 0; n < 10*PRE; n++) begin
            @(negedge clk);
            if (coarse_gray !== prev) begin
                changes++;
                if (gray_to_bin(coarse_gray) !== gray_to_bin(prev) + 24'd1) bad++;
                if ($countones(coarse_gray ^ prev) != 1) bad++;
                prev = coarse_gray;
            end
        end
        chk("R2 tick count", 64'(changes), 10);
        chk("R2 gray steps", 64'(bad), 0);
    endtask

    task automatic t_first_hit;
        @(negedge clk); trig_in = 16'h0008;
        @(negedge clk);
        chk("R3 or high", 64'(trig_or), 1);
        chk("R5 no early hold", 64'(hold_strobe), 0);
        g0 = coarse_gray;
        @(negedge clk);
        chk("R5 hold pulse", 64'(hold_strobe), 64'(32'h1 << 6));
        chk("R5 valid set", 64'(cell_valid), 64'(32'h1 << 6));
        chk("R5 hit status", 64'(hit_status), 16'h0008);
        @(negedge clk);
        chk("R5 hold one cycle", 64'(hold_strobe), 0);
        repeat (3) @(negedge clk);
        chk("R4 held trigger one entry", 64'(cell_valid), 64'(32'h1 << 6));
        chk("R4 no extra hold", 64'(hold_strobe), 0);
        trig_in = '0;
        @(negedge clk);
        chk("R3 or low", 64'(trig_or), 0);
        rd_ch = 4'd3;
        #1;
        chk("R7 stored ts", 64'(rd_ts), 64'(g0));
        chk("R7 rd col", 64'(rd_col), 0);
        chk("R6 next col", 64'(wr_col[3]), 1);
    endtask

    task automatic t_second_hit;
        @(negedge clk); trig_in = 16'h0008;
        @(negedge clk); trig_in = '0; g1 = coarse_gray;
        @(negedge clk);
        chk("R6 second cell hold", 64'(hold_strobe), 64'(32'h1 << 7));
        chk("R6 both valid", 64'(cell_valid), 64'(32'h3 << 6));
        chk("R7 oldest kept", 64'(rd_ts), 64'(g0));
    endtask

    task automatic t_overflow;
        @(negedge clk); trig_in = 16'h0008;
        @(negedge clk); trig_in = '0;
        @(negedge clk);
        chk("R8 dropped no hold", 64'(hold_strobe), 0);
        chk("R8 cells unchanged", 64'(cell_valid), 64'(32'h3 << 6));
        chk("R8 overflow set", 64'(overflow), 16'h0008);
        chk("R8 oldest unchanged", 64'(rd_ts), 64'(g0));
    endtask

    task automatic t_erase;
        @(negedge clk); erase_req = 1'b1; erase_ch = 4'd3;
        @(negedge clk); erase_req = 1'b0;
        chk("R9 erase oldest", 64'(erase_strobe), 64'(32'h1 << 6));
        chk("R9 valid after", 64'(cell_valid), 64'(32'h1 << 7));
        chk("R9 read moves", 64'(rd_ts), 64'(g1));
        chk("R9 read col", 64'(rd_col), 1);
        @(negedge clk);
        chk("R9 erase one cycle", 64'(erase_strobe), 0);
        erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
        chk("R9 erase second", 64'(erase_strobe), 64'(32'h1 << 7));
        chk("R9 empty", 64'(hit_status), 0);
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
        chk("R10 no strobe", 64'(erase_strobe), 0);
        chk("R10 valid stays", 64'(cell_valid), 0);
        chk("R10 overflow untouched", 64'(overflow), 16'h0008);
        @(negedge clk);
        chk("R8 overflow sticky", 64'(overflow), 16'h0008);
    endtask

    task automatic t_wrap;
        @(negedge clk); trig_in = 16'h0008;
        @(negedge clk); trig_in = '0;
        @(negedge clk);
        chk("R6 wraps to cell 0", 64'(hold_strobe), 64'(32'h1 << 6));
        erase_req = 1'b1; erase_ch = 4'd3;
        @(negedge clk); erase_req = 1'b0;
        chk("R9 wrap erase", 64'(erase_strobe), 64'(32'h1 << 6));
    endtask

    task automatic t_independent;
        @(negedge clk); trig_in = 16'h8001;
        @(negedge clk); trig_in = '0; g15 = coarse_gray;
        @(negedge clk);
        chk("R11 two channels", 64'(hold_strobe), 64'((32'h1 << 0) | (32'h1 << 30)));
        chk("R11 valid", 64'(cell_valid), 64'((32'h1 << 0) | (32'h1 << 30)));
        trig_in = 16'h0001;
        @(negedge clk); trig_in = '0; erase_req = 1'b1; erase_ch = 4'd0;
        @(negedge clk); erase_req = 1'b0;
        chk("R11 write with erase hold", 64'(hold_strobe), 64'(32'h1 << 1));
        chk("R11 write with erase strobe", 64'(erase_strobe), 64'(32'h1 << 0));
        chk("R11 valid after both", 64'(cell_valid), 64'((32'h1 << 1) | (32'h1 << 30)));
        chk("R11 no overflow ch0", 64'(overflow[0]), 0);
        rd_ch = 4'd15;
        #1;
        chk("R11 ch15 ts", 64'(rd_ts), 64'(g15));
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gray();
        t_first_hit();
        t_second_hit();
        t_overflow();
        t_erase();
        t_wrap();
        t_independent();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule